// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Controller

This block keeps a small group of private write-back caches coherent over one shared bus. Each cache is direct-mapped and holds one data word per block. Each line is in one of three states: invalid, shared (a clean copy that may also sit in other caches), or exclusive (the only copy, owned and possibly newer than memory). A processor access that hits with enough permission finishes inside its own cache. Any other access needs the bus: a read miss, a write miss, or a write to a shared line. One fixed-priority arbiter grants the bus to at most one cache per cycle. The order of grants is therefore the global order of writes.

Every other cache snoops each bus transaction. A bus write removes all other copies of the block. When another cache owns the requested block, that cache supplies the word instead of memory. A read leaves the owner holding a shared copy, and the word is flushed to memory. A write leaves the owner invalid, and memory stays stale. An exclusive victim is written back to memory when it is replaced. All the caches, the arbiter and a small backing memory sit in one module, with one request port per processor. Each request is acknowledged in the cycle it is served.

Top module: `snoop_inval_cache`

## Requirements
- R1: After reset every line in every cache is invalid, and memory word `a` holds `8'hC0 | a`. The first access of each cache therefore uses the bus, and memory supplies the data (`bus_intervene` = 0).
- R2: A read miss with no owner in another cache is served from memory and installs the block as shared. A later read of that block by the same cache completes without the bus (`bus_valid` = 0).
- R3: A write to a block that is not held exclusive uses the bus with `bus_write` = 1. The writer then holds the block exclusive. Every other cache's copy becomes invalid, so its next access to the block misses.
- R4: A write that hits an exclusive line completes locally in the same cycle, with `bus_valid` = 0.
- R5: A bus read of a block owned by another cache is supplied by the owner (`bus_intervene` = 1). The owner drops to shared, so its next write to that block uses the bus again.
- R6: A bus write that misses on a block owned by another cache is supplied by the owner (`bus_intervene` = 1), and the owner drops to invalid.
- R7: At most one cache holds any given block exclusive at any time.
- R8: Replacing an exclusive line writes its word back to memory. A later read of that block with no owner returns the written value from memory (`bus_intervene` = 0).
- R9: At most one cache uses the bus per cycle, and the lowest-numbered requesting cache wins. A cache that loses arbitration sees `ack` = 0 and is served in a later cycle.
- R10: When a cache's local hit and another cache's bus transaction target the same block in the same cycle, the snoop wins. The local request is not acknowledged that cycle, and it is retried against the updated line.
- R11: Every read returns the value of the most recent write to that address, in bus and completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-processor request valid, held until acknowledged |
| req_write | input | N | Per-processor request is a write |
| req_addr | input | N*AW | Per-processor word address, processor c in bits [c*AW +: AW] |
| req_wdata | input | N*DW | Per-processor write data |
| ack | output | N | Request of processor c is completed this cycle |
| rdata | output | N*DW | Read data, valid with ack |
| bus_valid | output | 1 | A bus transaction is under way this cycle |
| bus_write | output | 1 | The bus transaction is a write (invalidating) |
| bus_addr | output | AW | Block address on the bus |
| bus_intervene | output | 1 | A cache, not memory, supplies the bus data |

## Verification
A line left in the wrong state shows at the ports on the next access to that block. A stale shared copy returns an old word on a read that should have missed. A surviving owner flag shows as `bus_intervene` = 1 where memory should answer. A lost exclusive state shows as a bus transaction on a write that should be local. A missed write-back returns an old memory word after eviction. The bench keeps a protocol-level model of every line and a flat coherent memory image, and it predicts `bus_valid`, `bus_write`, `bus_intervene` and the read data for each access. A fault therefore shows in the cycle of the first access that touches the corrupted block.

// File: rtl/snoop_inval_cache.sv
module snoop_inval_cache #(
  parameter int N  = 3,
  parameter int AW = 4,
  parameter int IW = 2,
  parameter int DW = 8,
  parameter logic [DW-1:0] MEM_BASE = 'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    req_write,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  output logic [N-1:0]    ack,
  output logic [N*DW-1:0] rdata,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_intervene
);
  localparam int SETS = 1 << IW;
  localparam int TW   = AW - IW;
  localparam int MEMN = 1 << AW;
  localparam int CW   = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2;

  logic [1:0]    st  [N][SETS];
  logic [TW-1:0] tg  [N][SETS];
  logic [DW-1:0] dt  [N][SETS];
  logic [DW-1:0] mem [MEMN];

  logic [IW-1:0] cset [N];
  logic [TW-1:0] ctag [N];
  logic [N-1:0]  lok, need, own, snp, conf;
  logic [CW-1:0] g;
  logic [IW-1:0] bset;
  logic [TW-1:0] btag;
  logic [DW-1:0] bwd, odata, fill;
  logic          gsame, evict;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      cset[c] = req_addr[c*AW +: IW];
      ctag[c] = req_addr[c*AW+IW +: TW];
      lok[c]  = req_valid[c] && st[c][cset[c]] != ST_I && tg[c][cset[c]] == ctag[c]
                && (!req_write[c] || st[c][cset[c]] == ST_E);
      need[c] = req_valid[c] && !lok[c];
    end
  end

  always_comb begin
    g = '0;
    bus_valid = 1'b0;
    for (int c = 0; c < N; c++)
      if (need[c] && !bus_valid) begin
        g = CW'(c);
        bus_valid = 1'b1;
      end
  end

  assign bus_addr  = req_addr[int'(g)*AW +: AW];
  assign bus_write = bus_valid && req_write[g];
  assign bwd       = req_wdata[int'(g)*DW +: DW];
  assign bset      = bus_addr[IW-1:0];
  assign btag      = bus_addr[AW-1:IW];
  assign gsame     = st[g][bset] != ST_I && tg[g][bset] == btag;
  assign evict     = bus_valid && st[g][bset] == ST_E && !gsame;

  always_comb begin
    odata = '0;
    for (int c = 0; c < N; c++) begin
      snp[c]  = bus_valid && CW'(c) != g && st[c][bset] != ST_I && tg[c][bset] == btag;
      own[c]  = snp[c] && st[c][bset] == ST_E;
      conf[c] = bus_valid && CW'(c) != g && lok[c] && req_addr[c*AW +: AW] == bus_addr;
      if (own[c]) odata = dt[c][bset];
    end
  end

  assign bus_intervene = |own;
  assign fill = gsame ? dt[g][bset] : (bus_intervene ? odata : mem[bus_addr]);

  always_comb begin
    for (int c = 0; c < N; c++) begin
      ack[c] = (lok[c] && !conf[c]) || (bus_valid && g == CW'(c));
      rdata[c*DW +: DW] = lok[c] ? dt[c][cset[c]] : fill;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++)
        for (int s = 0; s < SETS; s++) begin
          st[c][s] <= ST_I;
          tg[c][s] <= '0;
          dt[c][s] <= '0;
        end
      for (int i = 0; i < MEMN; i++) mem[i] <= MEM_BASE | DW'(i);
    end else begin
      for (int c = 0; c < N; c++) begin
        if (lok[c] && !conf[c] && req_write[c]) dt[c][cset[c]] <= req_wdata[c*DW +: DW];
        if (snp[c]) begin
          if (bus_write) st[c][bset] <= ST_I;
          else if (own[c]) st[c][bset] <= ST_S;
        end
      end
      if (bus_valid) begin
        if (evict) mem[{tg[g][bset], bset}] <= dt[g][bset];
        if (bus_intervene && !bus_write) mem[bus_addr] <= odata;
        st[g][bset] <= bus_write ? ST_E : ST_S;
        tg[g][bset] <= btag;
        dt[g][bset] <= bus_write ? bwd : fill;
      end
    end
  end

  logic          p_bv, p_bwe, p_ev;
  logic [CW-1:0] p_g;
  logic [AW-1:0] p_addr, p_vaddr;
  logic [DW-1:0] p_vdata;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_bv <= 1'b0; p_bwe <= 1'b0; p_ev <= 1'b0;
      p_g <= '0; p_addr <= '0; p_vaddr <= '0; p_vdata <= '0;
    end else begin
      p_bv <= bus_valid; p_bwe <= bus_write; p_ev <= evict;
      p_g <= g; p_addr <= bus_addr;
      p_vaddr <= {tg[g][bset], bset}; p_vdata <= dt[g][bset];
    end
  end

  p_writer_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_bv && p_bwe) |-> (st[p_g][p_addr[IW-1:0]] == ST_E && tg[p_g][p_addr[IW-1:0]] == p_addr[AW-1:IW]));
  p_reader_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_bv && !p_bwe) |-> st[p_g][p_addr[IW-1:0]] == ST_S);
  p_victim_saved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    p_ev |-> mem[p_vaddr] == p_vdata);

  for (genvar c = 0; c < N; c++) begin : g_chk
    p_copy_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (p_bv && p_bwe && p_g != CW'(c)) |->
      !(st[c][p_addr[IW-1:0]] != ST_I && tg[c][p_addr[IW-1:0]] == p_addr[AW-1:IW]));
    for (genvar j = c + 1; j < N; j++) begin : g_pair
      for (genvar s = 0; s < SETS; s++) begin : g_set
        p_one_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
          !(st[c][s] == ST_E && st[j][s] == ST_E && tg[c][s] == tg[j][s]));
      end
    end
  end
endmodule

// File: tb/sim_snoop_inval_cache.sv
module sim_snoop_inval_cache;
  localparam int N = 3, AW = 4, IW = 2, DW = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = '0, req_write = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0] ack;
  logic [N*DW-1:0] rdata;
  logic bus_valid, bus_write, bus_intervene;
  logic [AW-1:0] bus_addr;

  snoop_inval_cache #(.N(N), .AW(AW), .IW(IW), .DW(DW)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int mst [N][4];
  int mtg [N][4];
  logic [7:0] gold [16];
  bit e_bus, e_iv;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // protocol-level prediction and update, 0=I 1=S 2=E
  task automatic mdl(input int c, input bit we, input int a, input logic [7:0] d);
    int s = a % 4, t = a / 4;
    bit hit = mst[c][s] != 0 && mtg[c][s] == t;
    e_bus = !(hit && (!we || mst[c][s] == 2));
    e_iv = 0;
    if (e_bus) begin
      for (int o = 0; o < N; o++)
        if (o != c && mst[o][s] == 2 && mtg[o][s] == t) e_iv = 1;
      for (int o = 0; o < N; o++)
        if (o != c && mst[o][s] != 0 && mtg[o][s] == t) begin
          if (we) mst[o][s] = 0;
          else if (mst[o][s] == 2) mst[o][s] = 1;
        end
      mst[c][s] = we ? 2 : 1;
      mtg[c][s] = t;
    end
    if (we) gold[a] = d;
  endtask

  task automatic drive(input int c, input bit we, input int a, input logic [7:0] d);
    req_valid[c] = 1; req_write[c] = we;
    req_addr[c*AW +: AW] = AW'(a); req_wdata[c*DW +: DW] = d;
  endtask

  task automatic op(input int c, input bit we, input int a, input logic [7:0] d, input string tag);
    logic [7:0] exp_rd;
    @(negedge clk);
    drive(c, we, a, d);
    exp_rd = gold[a];
    mdl(c, we, a, d);
    #1;
    chk(ack[c] == 1, {tag, " ack"}, ack[c], 1);
    chk(bus_valid == e_bus, {tag, " bus_valid"}, bus_valid, e_bus);
    if (e_bus) begin
      chk(bus_write == we, {tag, " bus_write"}, bus_write, we);
      chk(bus_intervene == e_iv, {tag, " bus_intervene"}, bus_intervene, e_iv);
    end
    if (!we) chk(rdata[c*DW +: DW] == exp_rd, {tag, " R11 rdata"}, rdata[c*DW +: DW], exp_rd);
    @(posedge clk); #1;
    req_valid[c] = 0;
  endtask

  initial begin
    #(4*150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int c = 0; c < N; c++) for (int s = 0; s < 4; s++) begin mst[c][s] = 0; mtg[c][s] = 0; end
    for (int i = 0; i < 16; i++) gold[i] = 8'hC0 | 8'(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(ack == 0 && bus_valid == 0, "R1 idle after reset", {ack, bus_valid}, 0);

    op(0, 0, 3, 0, "R1 first read from memory");
    op(0, 0, 3, 0, "R2 shared read hit local");
    op(1, 0, 3, 0, "R2 second sharer");
    op(0, 1, 3, 8'h11, "R3 upgrade invalidates");
    op(1, 0, 3, 0, "R3 R5 invalidated copy misses owner supplies");
    op(0, 1, 3, 8'h12, "R5 former owner now shared");
    op(0, 1, 3, 8'h22, "R4 exclusive write local");
    op(2, 1, 3, 8'h33, "R6 write miss owner supplies");
    op(0, 0, 3, 0, "R6 old owner invalid");
    op(1, 1, 5, 8'h44, "R8 own block");
    op(1, 0, 9, 0, "R8 evict exclusive");
    op(2, 0, 5, 0, "R8 written back in memory");

    // R9: two misses in one cycle
    @(negedge clk);
    drive(1, 0, 12, 0); drive(2, 0, 13, 0);
    #1;
    chk(ack[1] == 1 && ack[2] == 0, "R9 lowest index wins", ack, 3'b010);
    chk(bus_addr == 12, "R9 bus address of winner", bus_addr, 12);
    chk(rdata[1*DW +: DW] == gold[12], "R9 winner data", rdata[1*DW +: DW], gold[12]);
    mdl(1, 0, 12, 0);
    @(posedge clk); #1;
    req_valid[1] = 0; #1;
    chk(ack[2] == 1 && bus_addr == 13, "R9 loser served next cycle", {ack[2], bus_addr}, {1'b1, 4'd13});
    chk(rdata[2*DW +: DW] == gold[13], "R9 loser data", rdata[2*DW +: DW], gold[13]);
    mdl(2, 0, 13, 0);
    @(posedge clk); #1;
    req_valid[2] = 0;

    // R10: snoop wins over local hit on the same block
    op(0, 0, 6, 0, "R10 setup c0");
    op(1, 0, 6, 0, "R10 setup c1");
    @(negedge clk);
    drive(0, 0, 6, 0); drive(1, 1, 6, 8'h55);
    #1;
    chk(ack[0] == 0 && ack[1] == 1, "R10 local hit held", ack[1:0], 2'b10);
    chk(bus_write == 1 && bus_addr == 6, "R10 bus write", {bus_write, bus_addr}, {1'b1, 4'd6});
    mdl(1, 1, 6, 8'h55);
    @(posedge clk); #1;
    req_valid[1] = 0; #1;
    mdl(0, 0, 6, 0);
    chk(ack[0] == 1 && bus_valid == 1 && bus_intervene == 1, "R10 retry misses, owner supplies",
        {ack[0], bus_valid, bus_intervene}, 3'b111);
    chk(rdata[7:0] == 8'h55, "R10 R11 retry data", rdata[7:0], 8'h55);
    @(posedge clk); #1;
    req_valid[0] = 0;

    // sweep every address, core and direction
    for (int a = 0; a < 16; a++)
      for (int c = 0; c < N; c++)
        for (int w = 0; w < 2; w++)
          op(c, w[0], a, 8'(a*16 + c*4 + w), "R11 sweep");
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op(int'(lf[1:0]) % N, lf[2], int'(lf[6:3]), lf[15:8], "R7 R11 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule